// File: doc/BRIEF.md
# Associative Sparse Partial-Sum Accumulator

This block builds a sparse result vector in compressed form, with each entry tagged by its row index. Every input beat carries a row index, a matrix value and a vector value. The block searches a content-addressable array of stored row indices for the incoming index.

On a hit, the partial sum is read from a parallel value array, at the row that matched. On a miss, the partial sum is taken as zero and a new entry is allocated. The product of the two values is then added to the partial sum, and the result is written back. The multiply-add is done in wrap-around integer arithmetic of a parameterised width.

The work runs as a five-stage pipeline: capture, lookup, value read, multiply-add and write-back. A new beat can enter on every cycle. The pipeline stays exact when beats one, two or three cycles apart carry the same index. Index comparison against the beats still in flight keeps such beats on one entry, and two forwarding points deliver the newest sum. No beat is lost and no entry is duplicated.

A clear pulse empties the store. A done pulse stops intake, waits for the pipeline to empty, and then streams the stored (index, value) pairs. They come out in the order the indices were first seen, under a valid/ready handshake with a last marker. An allocation that finds every entry in use sets a sticky overflow flag and drops that beat.

Top module: `sparse_psum_acc`

## Requirements
- R1: After reset or a clear pulse (`clr_i` high for one cycle), the store holds no entries and `ovf_o` is 0. A done pulse that follows then produces no output beat. Clear takes priority over every other input in the same cycle.
- R2: A beat whose index is not stored and not in flight allocates a new entry. The value of that entry is the product of the beat's two values, taken as the low DATA_W bits.
- R3: A beat whose index is already stored adds the low DATA_W bits of its product to the entry, modulo 2^DATA_W. This holds for beats accepted on consecutive cycles, including same-index beats 1, 2, 3 or more cycles apart.
- R4: Readout presents entries in the order their indices first arrived, not sorted by index. The readout starts at storage slot 0, and `out_last_o` is 1 on the final pair only.
- R5: At most one stored entry ever matches a given index, so each distinct accepted index appears exactly once in the readout.
- R6: When a beat needs a new entry while all DEPTH entries are in use, `ovf_o` goes to 1 and stays 1 until a clear, and the beat is dropped. Beats that hit existing entries keep accumulating.
- R7: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o`, `out_idx_o` and `out_val_o` hold their values.
- R8: Input beats presented after the cycle in which `done_i` is sampled, up to the next clear, are ignored.
- R9: Beats accepted up to and including the cycle of `done_i` are fully accumulated before the first readout pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Clear pulse: empties the store and restarts accumulation |
| done_i | input | 1 | End of input: drain the pipeline, then stream the results |
| in_valid_i | input | 1 | Input beat present (accepted when accumulating) |
| in_idx_i | input | IDX_W | Row index of the beat |
| in_mat_i | input | DATA_W | Matrix value |
| in_vec_i | input | DATA_W | Vector value |
| out_valid_o | output | 1 | Readout pair present |
| out_ready_i | input | 1 | Readout pair accepted |
| out_idx_o | output | IDX_W | Stored row index |
| out_val_o | output | DATA_W | Accumulated sum |
| out_last_o | output | 1 | Final stored pair |
| ovf_o | output | 1 | Sticky overflow: an allocation was refused |

## Verification
The assertions check the following on every cycle:
- the index array never has more than one matching row;
- write-back allocates only into an unused row;
- the allocation count never exceeds the depth;
- overflow stays set until a clear;
- the pipeline is empty while streaming;
- readout data holds under backpressure.

Only the bench scenarios can show the arithmetic outcome of same-index beats at each pipeline distance. The same holds for first-seen storage order, for beats ignored after done, and for a dropped update that leaves its index absent while other sums keep growing. The bench compares each streamed pair against a model that is updated beat by beat.

// File: rtl/sacc_pkg.sv
package sacc_pkg;
  typedef enum logic [1:0] {
    ST_ACC   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_READ  = 2'd2,
    ST_HOLD  = 2'd3
  } sacc_state_e;
endpackage

// File: rtl/sacc_idx_cam.sv
module sacc_idx_cam #(
  parameter int DEPTH  = 64,
  parameter int IDX_W  = 64,
  parameter int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic [IDX_W-1:0]  srch_key_i,
  output logic              hit_o,
  output logic [SLOT_W-1:0] hit_slot_o,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [IDX_W-1:0]  wr_key_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [IDX_W-1:0]  rd_key_o
);
  logic [IDX_W-1:0] key_q [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d, match;

  // search port: one comparator per row, qualified by the row valid bit
  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    assign match[g] = vld_q[g] && (key_q[g] == srch_key_i);
    always_ff @(posedge clk) begin
      if (wr_en_i && (wr_slot_i == SLOT_W'(g))) key_q[g] <= wr_key_i;
    end
  end

  always_comb begin
    hit_o      = |match;
    hit_slot_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) hit_slot_o = hit_slot_o | SLOT_W'(i);
    end
  end

  always_comb begin
    vld_d = vld_q;
    if (clr_i) vld_d = '0;
    else if (wr_en_i) vld_d[wr_slot_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign rd_key_o = key_q[rd_slot_i];

  AST_CAM_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R5
  AST_CAM_FRESH_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |-> !vld_q[wr_slot_i]); // R5
endmodule

// File: rtl/sacc_val_ram.sv
module sacc_val_ram #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 64,
  parameter int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem_q[wr_slot_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_slot_i];
endmodule

// File: rtl/sacc_mac.sv
module sacc_mac #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] mat_i,
  input  logic [DATA_W-1:0] vec_i,
  output logic [DATA_W-1:0] sum_o
);
  logic [DATA_W-1:0] prod;

  always_comb begin
    prod  = mat_i * vec_i;
    sum_o = acc_i + prod;
  end
endmodule

// File: rtl/sparse_psum_acc.sv
module sparse_psum_acc
  import sacc_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int IDX_W  = 64,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              done_i,
  input  logic              in_valid_i,
  input  logic [IDX_W-1:0]  in_idx_i,
  input  logic [DATA_W-1:0] in_mat_i,
  input  logic [DATA_W-1:0] in_vec_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [IDX_W-1:0]  out_idx_o,
  output logic [DATA_W-1:0] out_val_o,
  output logic              out_last_o,
  output logic              ovf_o
);
  localparam int SLOT_W = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  sacc_state_e st_q, st_d;
  logic [CNT_W-1:0] alloc_q, alloc_d, ptr_q, ptr_d;
  logic             ovf_q, ovf_d;

  // stage registers: lk = lookup, rd = value read, mc = multiply-add, wb = write-back
  logic              lk_v_q, rd_v_q, mc_v_q, wb_v_q;
  logic [IDX_W-1:0]  lk_idx_q, rd_idx_q, mc_idx_q, wb_idx_q;
  logic [DATA_W-1:0] lk_a_q, lk_b_q, rd_a_q, rd_b_q, mc_a_q, mc_b_q;
  logic [SLOT_W-1:0] rd_slot_q, mc_slot_q, wb_slot_q;
  logic              rd_new_q, mc_new_q, wb_new_q;
  logic [DATA_W-1:0] mc_base_q, wb_sum_q;

  logic              cam_hit, fly_hit, any_hit, room;
  logic [SLOT_W-1:0] cam_slot, fly_slot, lk_slot, ram_rd_slot;
  logic              lk_go, lk_alloc, lk_drop, pipe_empty, out_fire;
  logic [DATA_W-1:0] ram_rd_data, rd_base, mc_acc, mc_sum;
  logic              wb_wr, cam_wr;

  // ---------------- lookup stage ----------------
  sacc_idx_cam #(.DEPTH(DEPTH), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_cam (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .srch_key_i (lk_idx_q),
    .hit_o      (cam_hit),
    .hit_slot_o (cam_slot),
    .wr_en_i    (cam_wr),
    .wr_slot_i  (wb_slot_q),
    .wr_key_i   (wb_idx_q),
    .rd_slot_i  (ptr_q[SLOT_W-1:0]),
    .rd_key_o   (out_idx_o)
  );

  // older beats not yet committed to the index array
  always_comb begin
    fly_hit  = 1'b0;
    fly_slot = '0;
    if (rd_v_q && rd_idx_q == lk_idx_q) begin
      fly_hit  = 1'b1;
      fly_slot = rd_slot_q;
    end else if (mc_v_q && mc_idx_q == lk_idx_q) begin
      fly_hit  = 1'b1;
      fly_slot = mc_slot_q;
    end else if (wb_v_q && wb_idx_q == lk_idx_q) begin
      fly_hit  = 1'b1;
      fly_slot = wb_slot_q;
    end
  end

  always_comb begin
    any_hit  = cam_hit || fly_hit;
    room     = alloc_q < CNT_W'(DEPTH);
    lk_alloc = lk_v_q && !any_hit && room;
    lk_drop  = lk_v_q && !any_hit && !room;
    lk_go    = lk_v_q && (any_hit || room);
    lk_slot  = fly_hit ? fly_slot : (cam_hit ? cam_slot : alloc_q[SLOT_W-1:0]);
  end

  // ---------------- value read stage ----------------
  assign ram_rd_slot = (st_q == ST_READ) ? ptr_q[SLOT_W-1:0] : rd_slot_q;

  sacc_val_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_val (
    .clk       (clk),
    .wr_en_i   (wb_wr),
    .wr_slot_i (wb_slot_q),
    .wr_data_i (wb_sum_q),
    .rd_slot_i (ram_rd_slot),
    .rd_data_o (ram_rd_data)
  );

  always_comb begin
    if (rd_new_q)                              rd_base = '0;
    else if (wb_v_q && wb_slot_q == rd_slot_q) rd_base = wb_sum_q;
    else                                       rd_base = ram_rd_data;
  end

  // ---------------- multiply-add stage ----------------
  assign mc_acc = (wb_v_q && wb_slot_q == mc_slot_q) ? wb_sum_q : mc_base_q;

  sacc_mac #(.DATA_W(DATA_W)) u_mac (
    .acc_i (mc_acc),
    .mat_i (mc_a_q),
    .vec_i (mc_b_q),
    .sum_o (mc_sum)
  );

  // ---------------- write-back stage ----------------
  assign wb_wr  = wb_v_q && !clr_i;
  assign cam_wr = wb_v_q && wb_new_q && !clr_i;

  // ---------------- pipeline registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_v_q <= 1'b0;
      rd_v_q <= 1'b0;
      mc_v_q <= 1'b0;
      wb_v_q <= 1'b0;
    end else begin
      lk_v_q <= in_valid_i && (st_q == ST_ACC) && !clr_i;
      rd_v_q <= lk_go && !clr_i;
      mc_v_q <= rd_v_q && !clr_i;
      wb_v_q <= mc_v_q && !clr_i;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid_i) begin
      lk_idx_q <= in_idx_i;
      lk_a_q   <= in_mat_i;
      lk_b_q   <= in_vec_i;
    end
    if (lk_v_q) begin
      rd_idx_q  <= lk_idx_q;
      rd_slot_q <= lk_slot;
      rd_new_q  <= !any_hit;
      rd_a_q    <= lk_a_q;
      rd_b_q    <= lk_b_q;
    end
    if (rd_v_q) begin
      mc_idx_q  <= rd_idx_q;
      mc_slot_q <= rd_slot_q;
      mc_new_q  <= rd_new_q;
      mc_base_q <= rd_base;
      mc_a_q    <= rd_a_q;
      mc_b_q    <= rd_b_q;
    end
    if (mc_v_q) begin
      wb_idx_q  <= mc_idx_q;
      wb_slot_q <= mc_slot_q;
      wb_new_q  <= mc_new_q;
      wb_sum_q  <= mc_sum;
    end
  end

  // ---------------- control ----------------
  assign pipe_empty  = !lk_v_q && !rd_v_q && !mc_v_q && !wb_v_q;
  assign out_valid_o = (st_q == ST_READ) && (ptr_q < alloc_q);
  assign out_last_o  = out_valid_o && (ptr_q == alloc_q - CNT_W'(1));
  assign out_val_o   = ram_rd_data;
  assign out_fire    = out_valid_o && out_ready_i;
  assign ovf_o       = ovf_q;

  always_comb begin
    st_d    = st_q;
    alloc_d = alloc_q;
    ptr_d   = ptr_q;
    ovf_d   = ovf_q;
    if (clr_i) begin
      st_d    = ST_ACC;
      alloc_d = '0;
      ptr_d   = '0;
      ovf_d   = 1'b0;
    end else begin
      if (lk_alloc) alloc_d = alloc_q + CNT_W'(1);
      if (lk_drop)  ovf_d   = 1'b1;
      unique case (st_q)
        ST_ACC:   if (done_i) st_d = ST_DRAIN;
        ST_DRAIN: if (pipe_empty) begin
          st_d  = ST_READ;
          ptr_d = '0;
        end
        ST_READ: begin
          if (alloc_q == '0) st_d = ST_HOLD;
          else if (out_fire) begin
            if (out_last_o) st_d = ST_HOLD;
            else            ptr_d = ptr_q + CNT_W'(1);
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_ACC;
      alloc_q <= '0;
      ptr_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      alloc_q <= alloc_d;
      ptr_q   <= ptr_d;
      ovf_q   <= ovf_d;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !clr_i |=> ovf_q); // R6
  AST_ALLOC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_q <= CNT_W'(DEPTH)); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i && !clr_i |=>
      out_valid_o && $stable(out_idx_o) && $stable(out_val_o)); // R7
  AST_READ_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> pipe_empty); // R9
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !out_valid_o && !ovf_q); // R1
endmodule

// File: tb/sparse_psum_acc_bench.sv
module sparse_psum_acc_bench;
  localparam int DEPTH  = 8;
  localparam int IDX_W  = 16;
  localparam int DATA_W = 16;

  logic              clk, rst_n, clr_i, done_i, in_valid_i, out_ready_i;
  logic [IDX_W-1:0]  in_idx_i, out_idx_o;
  logic [DATA_W-1:0] in_mat_i, in_vec_i, out_val_o;
  logic              out_valid_o, out_last_o, ovf_o;

  sparse_psum_acc #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_sparse_psum_acc (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .done_i(done_i),
    .in_valid_i(in_valid_i), .in_idx_i(in_idx_i), .in_mat_i(in_mat_i), .in_vec_i(in_vec_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_idx_o(out_idx_o),
    .out_val_o(out_val_o), .out_last_o(out_last_o), .ovf_o(ovf_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  logic [DATA_W-1:0] mv [int];
  int                ord [$];
  bit                exp_ovf;
  bit                accepting;
  // scoreboard
  logic [IDX_W-1:0]  eq_idx [$];
  logic [DATA_W-1:0] eq_val [$];
  bit                saw_out, saw_foreign;

  task automatic model_clear();
    mv.delete();
    ord.delete();
    exp_ovf = 1'b0;
  endtask

  task automatic beat(input logic [IDX_W-1:0] idx, input logic [DATA_W-1:0] a,
                      input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] p;
    in_valid_i = 1'b1;
    in_idx_i   = idx;
    in_mat_i   = a;
    in_vec_i   = b;
    p = a * b;
    if (accepting) begin
      if (mv.exists(int'(idx))) mv[int'(idx)] = mv[int'(idx)] + p;
      else if (ord.size() < DEPTH) begin
        mv[int'(idx)] = p;
        ord.push_back(int'(idx));
      end else exp_ovf = 1'b1;
    end
    @(posedge clk); #1;
    in_valid_i = 1'b0;
  endtask

  task automatic pulse_clear();
    clr_i = 1'b1;
    @(posedge clk); #1;
    clr_i = 1'b0;
    model_clear();
    accepting = 1'b1;
  endtask

  task automatic pulse_done();
    done_i = 1'b1;
    @(posedge clk); #1;
    done_i = 1'b0;
    accepting = 1'b0;
    foreach (ord[i]) begin
      eq_idx.push_back(IDX_W'(ord[i]));
      eq_val.push_back(mv[ord[i]]);
    end
  endtask

  task automatic wait_stream(input string tag);
    int n = 0;
    while (eq_idx.size() != 0 && n < 400) begin
      @(posedge clk);
      n++;
    end
    repeat (10) @(posedge clk);
    #1;
    chk(eq_idx.size() == 0, {tag, " all entries streamed"}, eq_idx.size(), 0);
  endtask

  // ready pattern
  bit throttle;
  int cyc;
  always @(posedge clk) begin
    #1;
    cyc++;
    out_ready_i = !throttle || (cyc % 3 != 0);
  end

  // monitor
  bit                hold_pend;
  logic [IDX_W-1:0]  h_idx;
  logic [DATA_W-1:0] h_val;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        chk(out_valid_o && out_idx_o == h_idx && out_val_o == h_val,
            "R7 output held under backpressure", {out_idx_o, out_val_o}, {h_idx, h_val});
      hold_pend = out_valid_o && !out_ready_i;
      h_idx = out_idx_o;
      h_val = out_val_o;
      if (out_valid_o) saw_out = 1'b1;
      if (out_valid_o && out_idx_o == 16'h4444) saw_foreign = 1'b1;
      if (out_valid_o && out_ready_i) begin
        if (eq_idx.size() == 0) chk(1'b0, "R1 unexpected readout pair", out_idx_o, 0);
        else begin
          logic [IDX_W-1:0]  ei;
          logic [DATA_W-1:0] ev;
          bit                el;
          ei = eq_idx.pop_front();
          ev = eq_val.pop_front();
          el = (eq_idx.size() == 0);
          chk(out_idx_o == ei, "R4 index in first-seen order", out_idx_o, ei);
          chk(out_val_o == ev, "R3 accumulated value", out_val_o, ev);
          chk(out_last_o == el, "R4 last marker", out_last_o, el);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr_i = 1'b0; done_i = 1'b0; in_valid_i = 1'b0;
    in_idx_i = '0; in_mat_i = '0; in_vec_i = '0; out_ready_i = 1'b1;
    throttle = 1'b0; cyc = 0; accepting = 1'b1; hold_pend = 1'b0;
    saw_out = 1'b0; saw_foreign = 1'b0;
    model_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid_o == 1'b0, "R1 reset no output", out_valid_o, 0);
    chk(ovf_o == 1'b0, "R1 reset overflow clear", ovf_o, 0);
    @(posedge clk); #1;

    // R2 R3 R5: unsorted indices, same-index beats 1..5 cycles apart, done while in flight (R9)
    beat(16'h0500, 16'd3, 16'd4);
    beat(16'h0030, 16'd5, 16'd6);
    beat(16'h9000, 16'd7, 16'd2);
    beat(16'h0030, 16'd1, 16'd9);
    beat(16'h0030, 16'd2, 16'd2);
    beat(16'h0500, 16'd10, 16'd10);
    beat(16'h9000, 16'd3, 16'd3);
    beat(16'h0007, 16'd8, 16'd8);
    beat(16'h0500, 16'd1, 16'd1);
    beat(16'h0007, 16'd4, 16'd2);
    pulse_done();
    wait_stream("R9 scenario A");

    // R7 backpressure, R8 beats ignored after done
    pulse_clear();
    throttle = 1'b1;
    saw_foreign = 1'b0;
    beat(16'h0100, 16'd2, 16'd3);
    beat(16'h0100, 16'd2, 16'd3);
    beat(16'h0002, 16'd9, 16'd9);
    beat(16'h0100, 16'd1, 16'd1);
    beat(16'h0002, 16'd1, 16'd1);
    beat(16'h0050, 16'd6, 16'd6);
    pulse_done();
    for (int k = 0; k < 6; k++) beat(16'h4444, 16'd1, 16'd1);
    wait_stream("R7 scenario B");
    chk(!saw_foreign, "R8 beat after done ignored", saw_foreign, 0);
    throttle = 1'b0;

    // R1 clear then done: empty readout
    pulse_clear();
    saw_out = 1'b0;
    pulse_done();
    repeat (20) @(posedge clk);
    #1;
    chk(!saw_out, "R1 empty store streams nothing", saw_out, 0);

    // R6 overflow: ten distinct indices, depth eight
    pulse_clear();
    for (int k = 0; k < 10; k++) beat(IDX_W'(16'h0200 + k * 3), DATA_W'(k + 1), 16'd2);
    beat(16'h0200, 16'd5, 16'd5);
    beat(16'h0200 + 16'd27, 16'd5, 16'd5);
    beat(16'h0203, 16'd1, 16'd7);
    @(negedge clk);
    chk(ovf_o == 1'b1, "R6 overflow flagged", ovf_o, exp_ovf);
    @(posedge clk); #1;
    pulse_done();
    wait_stream("R6 scenario D");
    chk(ovf_o == 1'b1, "R6 overflow sticky", ovf_o, 1);
    pulse_clear();
    @(negedge clk);
    chk(ovf_o == 1'b0, "R1 clear resets overflow", ovf_o, 0);
    @(posedge clk); #1;

    // R3 wrap-around arithmetic
    beat(16'h1234, 16'hFFFF, 16'hFFFF);
    beat(16'h1234, 16'hFFFF, 16'hFFFF);
    beat(16'h00AA, 16'h00FF, 16'h0101);
    beat(16'h00AA, 16'd1, 16'd1);
    pulse_done();
    wait_stream("R3 scenario E");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule